// File: doc/BRIEF.md
# Multi-source reset sequencer

This block merges every reset cause of a small metering controller into one active-low reset for the processor and its digital logic. It then times the release on the 32768 Hz crystal clock. The crystal clock keeps running through every reset.

There are five causes:
- an external reset pin
- an emulator reset pin
- a supply-low comparator flag
- a crystal-failure flag
- a watchdog-overflow pulse

The two pins and the supply flag pull the reset low asynchronously. They are released through two-flop synchronizers. The crystal and watchdog flags come from logic in the same slow clock domain and are sampled directly. A watchdog overflow is therefore a one-cycle pulse.

Once every cause is gone, the processor stays in reset for a fixed number of slow-clock cycles. It is then released with a one-cycle indication that fetching starts at address zero. Only the external pin and a supply-low episode produce the one-cycle strobe that wipes the I/O register file.

A five-bit status vector records which causes were seen during the last reset. Software can read it after the release. The supply-low flag also acts as the power-up reset of the sequencer itself.

Top module: `reset_sequencer`

## Requirements
- R1: `core_rst_n` is low while any cause is active: `ext_rst_n` low, `emu_rst_n` low, `vlow` high, or `xtal_fail`/`wdt_ovf` high at a rising clock edge.
- R2: A low level on `ext_rst_n` or `emu_rst_n`, or a high level on `vlow`, drives `core_rst_n` low without waiting for a clock edge.
- R3: When `ext_rst_n`, `emu_rst_n` or `vlow` returns inactive between two edges and no other cause is active, `core_rst_n` rises at rising edge number HOLD_CYC+SYNC_STAGES counted from that change.
- R4: When `xtal_fail` or `wdt_ovf` was last seen high at an edge and no other cause is active, `core_rst_n` rises HOLD_CYC edges after that edge; a single-cycle `wdt_ovf` pulse is enough to start a full reset.
- R5: A cause that appears while the hold count runs restarts it from zero, so release is timed from the last cause only.
- R6: `regs_clr` is a one-cycle pulse. It comes at the first edge after `ext_rst_n` falls, or at the first edge after `vlow` falls. There is exactly one pulse per episode, however long the pin stays low.
- R7: `emu_rst_n`, `xtal_fail` and `wdt_ovf` on their own never raise `regs_clr`.
- R8: `fetch_zero` is high for exactly one cycle, beginning at the same edge that raises `core_rst_n`.
- R9: `rst_cause` bit 0 = external pin, bit 1 = emulator pin, bit 2 = supply low, bit 3 = crystal, bit 4 = watchdog. A cause arriving while out of reset reloads the vector with the causes present at that edge. Causes arriving while in reset are ORed in. The vector stays unchanged while out of reset with no cause.
- R10: While `vlow` is high, `rst_cause` = 5'b00100 and `regs_clr` and `fetch_zero` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz crystal clock, free-running |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| emu_rst_n | input | 1 | Emulator reset pin, active low, asynchronous |
| vlow | input | 1 | Supply below threshold, active high, asynchronous |
| xtal_fail | input | 1 | Crystal malfunction flag, clk domain |
| wdt_ovf | input | 1 | Watchdog overflow pulse, clk domain |
| core_rst_n | output | 1 | Processor and digital reset, active low |
| regs_clr | output | 1 | One-cycle I/O register file clear strobe |
| fetch_zero | output | 1 | One-cycle pulse: start fetching at address 0 |
| rst_cause | output | 5 | Causes seen during the last reset |

## Verification
The bench builds the block with HOLD_CYC = 12 and SYNC_STAGES = 2. With these values every release edge can be counted exactly within a few dozen cycles, for both the two-stage pin path and the direct flag path. The short hold also leaves room to land a second cause in the middle of the count and to time the restart. At the default of 4100 cycles the same checks would need far longer runs.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int NCAUSE = 5;
  localparam int C_EXT  = 0;
  localparam int C_EMU  = 1;
  localparam int C_VLOW = 2;
  localparam int C_XTAL = 3;
  localparam int C_WDT  = 4;
  typedef logic [NCAUSE-1:0] cause_t;
  localparam cause_t CAUSE_PWRUP = cause_t'(1 << C_VLOW);
endpackage

// File: rtl/rstseq_sync.sv
// Reset-style synchronizer: asserts asynchronously, releases after STAGES edges.
module rstseq_sync #(
  parameter int STAGES     = 2,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic raw_in,
  output logic asserted
);
  logic              clr_n;
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign clr_n = ACTIVE_LOW ? raw_in : ~raw_in;

  always_comb begin
    chain_d = (chain_q << 1) | {{(STAGES-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign asserted = ~chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
// Hold counter: restarts on any cause, releases after HOLD_CYC quiet cycles.
module rstseq_timer #(
  parameter int HOLD_CYC = 4100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_cause,
  output logic busy,
  output logic fetch_pulse
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fz_q, fz_d;
  logic             cnt_en;

  assign cnt_en = busy_q & ~any_cause;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    fz_d   = 1'b0;
    if (any_cause) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        fz_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      fz_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      fz_q   <= fz_d;
    end
  end

  assign busy        = busy_q;
  assign fetch_pulse = fz_q;

  p_cause_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_cause |=> (busy_q && cnt_q == '0));
  p_release_after_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(cnt_q) == LAST);
  p_fetch_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> fz_q);
  p_fetch_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fz_q |=> !fz_q);
endmodule

// File: rtl/rstseq_status.sv
// Cause recorder and register-file clear strobe.
module rstseq_status
  import rstseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   busy,
  input  cause_t cause_vec,
  output cause_t cause_q,
  output logic   clr_strobe
);
  logic   hard_now;
  logic   hard_prev_q;
  logic   clr_q, clr_d;
  cause_t cause_d;
  logic   any_cause;

  assign hard_now  = cause_vec[C_EXT] | cause_vec[C_VLOW];
  assign any_cause = |cause_vec;

  always_comb begin
    cause_d = cause_q;
    if (any_cause) begin
      if (busy) cause_d = cause_q | cause_vec;
      else      cause_d = cause_vec;
    end
    clr_d = hard_now & ~hard_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q     <= CAUSE_PWRUP;
      hard_prev_q <= 1'b0;
      clr_q       <= 1'b0;
    end else begin
      cause_q     <= cause_d;
      hard_prev_q <= hard_now;
      clr_q       <= clr_d;
    end
  end

  assign clr_strobe = clr_q;

  p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
  p_clr_hard_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> $past(cause_vec[C_EXT] | cause_vec[C_VLOW]));
  p_cause_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_cause && !busy) |=> $stable(cause_q));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int HOLD_CYC    = 4100,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       emu_rst_n,
  input  logic       vlow,
  input  logic       xtal_fail,
  input  logic       wdt_ovf,
  output logic       core_rst_n,
  output logic       regs_clr,
  output logic       fetch_zero,
  output logic [4:0] rst_cause
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] LOW_MASK = 3'b011;

  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_act;
  cause_t          cause_vec;
  cause_t          cause_q;
  logic            any_cause;
  logic            busy;
  logic            seq_rst_n;

  assign pin_raw   = {vlow, emu_rst_n, ext_rst_n};
  assign seq_rst_n = ~vlow;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    rstseq_sync #(
      .STAGES     (SYNC_STAGES),
      .ACTIVE_LOW (LOW_MASK[i])
    ) u_sync (
      .clk      (clk),
      .raw_in   (pin_raw[i]),
      .asserted (pin_act[i])
    );
  end

  always_comb begin
    cause_vec          = '0;
    cause_vec[C_EXT]   = pin_act[0];
    cause_vec[C_EMU]   = pin_act[1];
    cause_vec[C_VLOW]  = pin_act[2];
    cause_vec[C_XTAL]  = xtal_fail;
    cause_vec[C_WDT]   = wdt_ovf;
  end

  assign any_cause = |cause_vec;

  rstseq_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (seq_rst_n),
    .any_cause   (any_cause),
    .busy        (busy),
    .fetch_pulse (fetch_zero)
  );

  rstseq_status u_status (
    .clk        (clk),
    .rst_n      (seq_rst_n),
    .busy       (busy),
    .cause_vec  (cause_vec),
    .cause_q    (cause_q),
    .clr_strobe (regs_clr)
  );

  assign core_rst_n = ~(busy | pin_act[0] | pin_act[1] | pin_act[2]);
  assign rst_cause  = cause_q;

  p_pin_holds_reset_r2: assert property (@(posedge clk) disable iff (vlow)
    (!ext_rst_n || !emu_rst_n) |-> !core_rst_n);
  p_flag_holds_reset_r1: assert property (@(posedge clk) disable iff (vlow)
    (xtal_fail || wdt_ovf) |=> !core_rst_n);
  p_fetch_out_of_reset_r8: assert property (@(posedge clk) disable iff (vlow)
    fetch_zero |-> core_rst_n);
endmodule

// File: tb/sim_reset_sequencer.sv
module sim_reset_sequencer;
  localparam int HOLD = 12;
  localparam int SYNC = 2;
  localparam int WD_LIMIT = 100000;
  localparam int NVEC = 8;
  // {mask[4:0], dur[7:0], pin_latency, exp_cause[4:0], exp_clr[1:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {5'b00001, 8'd4,  1'b1, 5'b00001, 2'd1},
    {5'b00010, 8'd30, 1'b1, 5'b00010, 2'd0},
    {5'b01000, 8'd3,  1'b0, 5'b01000, 2'd0},
    {5'b10000, 8'd1,  1'b0, 5'b10000, 2'd0},
    {5'b00001, 8'd30, 1'b1, 5'b00001, 2'd1},
    {5'b01001, 8'd5,  1'b1, 5'b01001, 2'd1},
    {5'b10010, 8'd2,  1'b1, 5'b10010, 2'd0},
    {5'b00100, 8'd6,  1'b1, 5'b00100, 2'd1}
  };

  logic clk = 1'b0;
  logic ext_rst_n, emu_rst_n, vlow, xtal_fail, wdt_ovf;
  logic core_rst_n, regs_clr, fetch_zero;
  logic [4:0] rst_cause;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  reset_sequencer #(.HOLD_CYC(HOLD), .SYNC_STAGES(SYNC)) u0 (
    .clk, .ext_rst_n, .emu_rst_n, .vlow, .xtal_fail, .wdt_ovf,
    .core_rst_n, .regs_clr, .fetch_zero, .rst_cause
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      $display("FAIL R1 watchdog expired act=%0d exp<=%0d", cyc, WD_LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] m);
    ext_rst_n = ~m[0];
    emu_rst_n = ~m[1];
    vlow      =  m[2];
    xtal_fail =  m[3];
    wdt_ovf   =  m[4];
  endtask

  // Counts negedges after a release until core_rst_n is high.
  task automatic wait_release(output int edges, inout int clrs, output int fz_rel);
    edges = 0;
    fz_rel = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      edges++;
      if (regs_clr) clrs++;
      if (core_rst_n) begin
        fz_rel = fetch_zero;
        break;
      end
    end
  endtask

  initial begin
    int edges, clrs, fz_rel, exp_edges;
    logic [4:0] snap;
    drive(5'b00100);
    repeat (5) @(negedge clk);
    // R10: state during supply-low
    chk(core_rst_n == 1'b0, "R10 core_rst_n in vlow", core_rst_n, 0);
    chk(rst_cause == 5'b00100, "R10 rst_cause in vlow", rst_cause, 5'b00100);
    chk(regs_clr == 1'b0 && fetch_zero == 1'b0, "R10 strobes idle in vlow",
        {regs_clr, fetch_zero}, 0);
    drive(5'b00000);
    clrs = 0;
    wait_release(edges, clrs, fz_rel);
    chk(edges == HOLD + SYNC, "R3 power-up release edge", edges, HOLD + SYNC);
    chk(clrs == 1, "R6 one clear after vlow", clrs, 1);
    chk(fz_rel == 1, "R8 fetch_zero at release", fz_rel, 1);
    @(negedge clk);
    chk(fetch_zero == 1'b0, "R8 fetch_zero single cycle", fetch_zero, 0);

    // Vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] m;
      int dur;
      m = VEC[v][20:16];
      dur = int'(VEC[v][15:8]);
      exp_edges = VEC[v][7] ? HOLD + SYNC : HOLD;
      clrs = 0;
      repeat (3) @(negedge clk);
      drive(m);
      for (int d = 0; d < dur; d++) begin
        @(negedge clk);
        if (regs_clr) clrs++;
      end
      chk(core_rst_n == 1'b0, $sformatf("R1 held low vec%0d", v), core_rst_n, 0);
      drive(5'b00000);
      wait_release(edges, clrs, fz_rel);
      chk(edges == exp_edges, $sformatf("R3/R4 release edge vec%0d", v), edges, exp_edges);
      chk(rst_cause == VEC[v][6:2], $sformatf("R9 cause vec%0d", v), rst_cause, VEC[v][6:2]);
      chk(clrs == int'(VEC[v][1:0]), $sformatf("R6/R7 clear count vec%0d", v),
          clrs, int'(VEC[v][1:0]));
      chk(fz_rel == 1, $sformatf("R8 fetch at release vec%0d", v), fz_rel, 1);
      snap = rst_cause;
      repeat (8) @(negedge clk);
      chk(rst_cause == snap && fetch_zero == 1'b0,
          $sformatf("R9 cause stable vec%0d", v), rst_cause, snap);
    end

    // R2: asynchronous assertion, no edge needed
    @(negedge clk);
    #2 ext_rst_n = 1'b0;
    #3 chk(core_rst_n == 1'b0, "R2 async assert ext", core_rst_n, 0);
    ext_rst_n = 1'b1;
    clrs = 0;
    wait_release(edges, clrs, fz_rel);
    @(negedge clk);
    #2 emu_rst_n = 1'b0;
    #3 chk(core_rst_n == 1'b0, "R2 async assert emu", core_rst_n, 0);
    emu_rst_n = 1'b1;
    wait_release(edges, clrs, fz_rel);

    // R5: restart mid-count, R9 accumulation
    repeat (3) @(negedge clk);
    clrs = 0;
    drive(5'b00001);
    repeat (3) @(negedge clk);
    drive(5'b00000);
    repeat (5) @(negedge clk);
    chk(core_rst_n == 1'b0, "R5 still held mid-count", core_rst_n, 0);
    drive(5'b01000);
    @(negedge clk);
    drive(5'b00000);
    wait_release(edges, clrs, fz_rel);
    chk(edges == HOLD, "R5 restart from last cause", edges, HOLD);
    chk(rst_cause == 5'b01001, "R9 accumulate during reset", rst_cause, 5'b01001);

    // R4: single watchdog pulse after a long quiet period
    repeat (20) @(negedge clk);
    clrs = 0;
    wdt_ovf = 1'b1;
    @(negedge clk);
    chk(core_rst_n == 1'b0, "R4 watchdog pulse resets", core_rst_n, 0);
    wdt_ovf = 1'b0;
    wait_release(edges, clrs, fz_rel);
    chk(edges == HOLD, "R4 watchdog release edge", edges, HOLD);
    chk(clrs == 0, "R7 no clear for watchdog", clrs, 0);
    chk(rst_cause == 5'b10000, "R9 fresh cause after release", rst_cause, 5'b10000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule